// File: doc/BRIEF.md
# Low-Power Clock Source Selector

This block decides which clock drives the system while the core sits in a low-power state. There are three candidate sources: an external primary clock, a secondary low-frequency clock, and an internal oscillator block. The internal block offers a slow RC clock or a fast oscillator followed by a power-of-two postscaler. Software writes a source-select field at any time. The field is acted on only when a sleep request arrives, so writing it does not disturb the clock that is running.

Every change of source goes through a glitch-free handoff. The old clock is stopped while it is low. The new clock is released only after its enable has passed two synchronizer stages in its own domain. A switch to the primary clock waits for a start-up-timer-done pulse. A switch to the secondary clock is refused when that oscillator is not enabled. Three status flags report the active source, and at most one of them is set at any time. When all three flags are clear, the slow RC clock is driving the system or the internal block is not yet stable. Control logic runs on an always-on control clock, `clk_i`.

Top module: `pm_clk_sel`

## Requirements
- R1: The select field is encoded as 00 for the primary clock, 01 for the secondary clock, and 10 or 11 for the internal block. Every reset clears the select field to 00, clears the frequency select to 000 and makes the internal block the active source (`active_src_o` = 2). `active_src_o` encodes the committed source as 0 = primary, 1 = secondary, 2 = internal.
- R2: Writing the select field leaves `active_src_o` and `sys_clk_o` unchanged until `sleep_i` is sampled high. The field value held before that cycle is the one applied.
- R3: A sleep request with the select field at 01 while `sec_en_i` is low is ignored, and the current source stays active.
- R4: A sleep request that selects the primary clock while another source is active leaves that source in place. The switch to the primary clock commits on the first later cycle in which `ost_done_i` is high.
- R5: `pri_run_o` is high only while the primary clock is committed and its handoff has finished. `sec_run_o` follows the same rule for the secondary clock. At most one of the three flags is high.
- R6: `int_ok_o` is high when the internal block is committed, its handoff has finished, `int_stable_i` is high and the frequency select is non-zero. With a frequency select of 000, or with `int_stable_i` low, all three flags are low.
- R7: With the internal block active, frequency select 000 routes the slow RC clock to `sys_clk_o`. A select k from 1 to 7 gives the fast clock divided by 2^(7-k): 7 passes the fast clock through and 1 divides it by 64.
- R8: A write to the frequency select changes the `sys_clk_o` period while the internal block is active, without any sleep request.
- R9: During a source handoff, `sys_clk_o` produces no high or low phase shorter than the shortest half-period among the sources involved, and at most one source gate is open at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_pri_i | input | 1 | Primary clock |
| clk_sec_i | input | 1 | Secondary low-frequency clock |
| clk_fast_i | input | 1 | Internal fast oscillator |
| clk_slow_i | input | 1 | Internal slow RC clock |
| sel_we_i | input | 1 | Write strobe for the source-select field |
| sel_i | input | 2 | New source-select value |
| ircf_we_i | input | 1 | Write strobe for the internal frequency select |
| ircf_i | input | 3 | New internal frequency select value |
| sleep_i | input | 1 | Sleep request, one control-clock cycle |
| sec_en_i | input | 1 | Secondary oscillator enabled |
| ost_done_i | input | 1 | Primary start-up timer done pulse |
| int_stable_i | input | 1 | Internal block is stable |
| sys_clk_o | output | 1 | Selected system clock |
| active_src_o | output | 2 | Committed source: 0 primary, 1 secondary, 2 internal |
| pri_run_o | output | 1 | Primary clock is driving |
| sec_run_o | output | 1 | Secondary clock is driving |
| int_ok_o | output | 1 | Internal block is stable and driving |

## Verification
A wrong committed-source register, such as a switch made early on a select write or a secondary switch that was not vetoed, shows on `active_src_o` one control clock after the faulty edge. The bench compares that output against its own model on every cycle. A gate or synchronizer fault shows up later, within a few source-clock periods: as a wrong status flag once the handoff has settled, as a wrong period on `sys_clk_o`, or as a runt pulse during a switch. A wrong postscaler tap shows as a `sys_clk_o` period off by a power of two within two output cycles of the frequency write.

// File: rtl/pm_clk_pkg.sv
package pm_clk_pkg;
  localparam int unsigned NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_e;

  function automatic src_e decode_sel(input logic [1:0] s);
    if (s[1]) return SRC_INT;
    return s[0] ? SRC_SEC : SRC_PRI;
  endfunction
endpackage

// File: rtl/pm_clk_ctrl.sv
module pm_clk_ctrl
  import pm_clk_pkg::*;
#(
  parameter int unsigned IRCF_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_we_i,
  input  logic [1:0]        sel_i,
  input  logic              ircf_we_i,
  input  logic [IRCF_W-1:0] ircf_i,
  input  logic              sleep_i,
  input  logic              sec_en_i,
  input  logic              ost_done_i,
  output src_e              cur_o,
  output logic [IRCF_W-1:0] ircf_o
);
  logic [1:0]        sel_q;
  logic [IRCF_W-1:0] ircf_q;
  src_e              cur_q;
  logic              pend_q;
  src_e              tgt;

  assign tgt = decode_sel(sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      ircf_q <= '0;
      cur_q  <= SRC_INT;
      pend_q <= 1'b0;
    end else begin
      if (sel_we_i)  sel_q  <= sel_i;
      if (ircf_we_i) ircf_q <= ircf_i;
      if (sleep_i) begin
        unique case (tgt)
          SRC_SEC: if (sec_en_i) begin   // vetoed when oscillator is off
            cur_q  <= SRC_SEC;
            pend_q <= 1'b0;
          end
          SRC_PRI: if (cur_q != SRC_PRI) pend_q <= 1'b1;
          default: begin
            cur_q  <= SRC_INT;
            pend_q <= 1'b0;
          end
        endcase
      end else if (pend_q && ost_done_i) begin
        cur_q  <= SRC_PRI;
        pend_q <= 1'b0;
      end
    end
  end

  assign cur_o  = cur_q;
  assign ircf_o = ircf_q;

  AST_SEL_DEFERRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i && !(pend_q && ost_done_i) |=> $stable(cur_q)); // R2
  AST_SEC_VETO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i && sel_q == 2'b01 && !sec_en_i |=> $stable(cur_q)); // R3
  AST_PRI_NEEDS_OST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q != SRC_PRI && !(pend_q && ost_done_i && !sleep_i) |=> cur_q != SRC_PRI); // R4
  AST_INT_ON_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i && sel_q[1] |=> cur_q == SRC_INT); // R1
endmodule

// File: rtl/pm_clk_postscaler.sv
module pm_clk_postscaler #(
  parameter int unsigned IRCF_W = 3
) (
  input  logic              clk_fast_i,
  input  logic              clk_slow_i,
  input  logic              rst_ni,
  input  logic [IRCF_W-1:0] ircf_i,
  output logic              clk_o
);
  localparam int unsigned NUM_TAP = 2 ** IRCF_W;
  localparam int unsigned DIV_W   = NUM_TAP - 2;

  logic [DIV_W-1:0]   cnt_q;
  logic [NUM_TAP-1:0] taps;

  always_ff @(posedge clk_fast_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign taps[0]         = clk_slow_i;
  assign taps[NUM_TAP-1] = clk_fast_i;
  for (genvar k = 1; k <= DIV_W; k++) begin : g_tap
    assign taps[k] = cnt_q[DIV_W-k];   // /2^(NUM_TAP-1-k)
  end

  assign clk_o = taps[ircf_i];
endmodule

// File: rtl/pm_clk_gate_mux.sv
module pm_clk_gate_mux #(
  parameter int unsigned N           = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         rst_ni,
  input  logic [N-1:0] clk_src_i,
  input  logic [N-1:0] sel_i,
  output logic [N-1:0] gate_o,
  output logic         clk_o
);
  logic [N-1:0] gate;

  for (genvar k = 0; k < N; k++) begin : g_src
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   gate_q;
    logic                   others_on;
    logic                   req;

    assign others_on = |(gate & ~(N'(1) << k));
    assign req       = sel_i[k] & ~others_on;

    always_ff @(posedge clk_src_i[k] or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], req};
    end

    // gate moves only while the source is low
    always_ff @(negedge clk_src_i[k] or negedge rst_ni) begin
      if (!rst_ni) gate_q <= 1'b0;
      else         gate_q <= sync_q[SYNC_STAGES-1];
    end

    assign gate[k] = gate_q;
  end

  assign gate_o = gate;
  assign clk_o  = |(clk_src_i & gate);
endmodule

// File: rtl/pm_clk_sel.sv
module pm_clk_sel
  import pm_clk_pkg::*;
#(
  parameter int unsigned IRCF_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_pri_i,
  input  logic              clk_sec_i,
  input  logic              clk_fast_i,
  input  logic              clk_slow_i,
  input  logic              sel_we_i,
  input  logic [1:0]        sel_i,
  input  logic              ircf_we_i,
  input  logic [IRCF_W-1:0] ircf_i,
  input  logic              sleep_i,
  input  logic              sec_en_i,
  input  logic              ost_done_i,
  input  logic              int_stable_i,
  output logic              sys_clk_o,
  output logic [1:0]        active_src_o,
  output logic              pri_run_o,
  output logic              sec_run_o,
  output logic              int_ok_o
);
  src_e               cur;
  logic [IRCF_W-1:0]  ircf;
  logic               clk_int;
  logic [NUM_SRC-1:0] sel_oh;
  logic [NUM_SRC-1:0] gate;
  logic [NUM_SRC-1:0] ack_s1, ack_s2;

  pm_clk_ctrl #(.IRCF_W(IRCF_W)) i_ctrl (
    .clk_i, .rst_ni, .sel_we_i, .sel_i, .ircf_we_i, .ircf_i,
    .sleep_i, .sec_en_i, .ost_done_i,
    .cur_o (cur),
    .ircf_o(ircf)
  );

  pm_clk_postscaler #(.IRCF_W(IRCF_W)) i_post (
    .clk_fast_i, .clk_slow_i, .rst_ni,
    .ircf_i(ircf),
    .clk_o (clk_int)
  );

  assign sel_oh = NUM_SRC'(1) << cur;

  pm_clk_gate_mux #(.N(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) i_mux (
    .rst_ni,
    .clk_src_i({clk_int, clk_sec_i, clk_pri_i}),
    .sel_i    (sel_oh),
    .gate_o   (gate),
    .clk_o    (sys_clk_o)
  );

  // gate state brought back into the control domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_s1 <= '0;
      ack_s2 <= '0;
    end else begin
      ack_s1 <= gate;
      ack_s2 <= ack_s1;
    end
  end

  assign active_src_o = cur;
  assign pri_run_o    = ack_s2[SRC_PRI] && cur == SRC_PRI;
  assign sec_run_o    = ack_s2[SRC_SEC] && cur == SRC_SEC;
  assign int_ok_o     = ack_s2[SRC_INT] && cur == SRC_INT && int_stable_i && |ircf;

  AST_GATE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gate)); // R9
  AST_ACK_TRACKS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_s2)); // R5
endmodule

// File: tb/test_pm_clk_sel.sv
`timescale 1ns/1ps
module test_pm_clk_sel;
  logic clk = 0, clk_pri = 0, clk_sec = 0, clk_fast = 0, clk_slow = 0;
  logic rst_ni = 0;
  logic sel_we = 0, ircf_we = 0, sleep = 0, sec_en = 0, ost_done = 0, int_stable = 1;
  logic [1:0] sel_d = 0;
  logic [2:0] ircf_d = 0;
  logic sys_clk, pri_run, sec_run, int_ok;
  logic [1:0] active_src;

  always #10  clk      = ~clk;
  always #7   clk_pri  = ~clk_pri;
  always #50  clk_sec  = ~clk_sec;
  always #5   clk_fast = ~clk_fast;
  always #150 clk_slow = ~clk_slow;

  pm_clk_sel i_pm_clk_sel (
    .clk_i(clk), .rst_ni, .clk_pri_i(clk_pri), .clk_sec_i(clk_sec),
    .clk_fast_i(clk_fast), .clk_slow_i(clk_slow), .sel_we_i(sel_we), .sel_i(sel_d),
    .ircf_we_i(ircf_we), .ircf_i(ircf_d), .sleep_i(sleep), .sec_en_i(sec_en),
    .ost_done_i(ost_done), .int_stable_i(int_stable), .sys_clk_o(sys_clk),
    .active_src_o(active_src), .pri_run_o(pri_run), .sec_run_o(sec_run), .int_ok_o(int_ok)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural model of the committed source
  int m_sel = 0, m_ircf = 0, m_cur = 2, m_pend = 0;
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_sel = 0; m_ircf = 0; m_cur = 2; m_pend = 0;
    end else begin
      int tgt;
      tgt = (m_sel >= 2) ? 2 : m_sel;
      if (sleep) begin
        if (tgt == 1) begin
          if (sec_en) begin m_cur = 1; m_pend = 0; end
        end else if (tgt == 0) begin
          if (m_cur != 0) m_pend = 1;
        end else begin
          m_cur = 2; m_pend = 0;
        end
      end else if (m_pend == 1 && ost_done) begin
        m_cur = 0; m_pend = 0;
      end
      if (sel_we) m_sel = int'(sel_d);
      if (ircf_we) m_ircf = int'(ircf_d);
    end
  end

  always @(negedge clk)
    if (rst_ni) chk(int'(active_src) == m_cur, "R2", "active_src per-cycle", int'(active_src), m_cur);

  // runt-pulse monitor for handoffs (R9)
  bit mon_en = 0;
  realtime t_edge = 0, min_phase = 1.0e9;
  always @(sys_clk) begin
    if (mon_en && t_edge > 0 && ($realtime - t_edge) < min_phase) min_phase = $realtime - t_edge;
    t_edge = $realtime;
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic pulse_sleep(); sleep = 1; cyc(1); sleep = 0; endtask
  task automatic wr_sel(input logic [1:0] v); sel_d = v; sel_we = 1; cyc(1); sel_we = 0; endtask
  task automatic wr_ircf(input logic [2:0] v); ircf_d = v; ircf_we = 1; cyc(1); ircf_we = 0; endtask

  task automatic chk_flags(input string req, input logic p, input logic s, input logic i);
    chk({pri_run, sec_run, int_ok} == {p, s, i}, req, "flags{pri,sec,int}",
        int'({pri_run, sec_run, int_ok}), int'({p, s, i}));
  endtask

  task automatic chk_period(input string req, input int exp_ns);
    realtime t0, p;
    @(posedge sys_clk); @(posedge sys_clk);
    t0 = $realtime;
    @(posedge sys_clk);
    p = $realtime - t0;
    chk(p > exp_ns - 0.5 && p < exp_ns + 0.5, req, "sys_clk period ns", int'(p), exp_ns);
    cyc(1);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1;
    cyc(200);
    // R1 reset state: internal active, ircf 000 -> all flags low (R6)
    chk(active_src == 2, "R1", "reset active_src", int'(active_src), 2);
    chk_flags("R6", 0, 0, 0);
    chk_period("R7", 300);

    // R4: reset select (00) picks primary, waits for ost_done
    mon_en = 1;
    pulse_sleep();
    cyc(30);
    chk(active_src == 2, "R4", "primary pending", int'(active_src), 2);
    ost_done = 1; cyc(1); ost_done = 0;
    chk(active_src == 0, "R4", "primary committed", int'(active_src), 0);
    cyc(200);
    chk_flags("R5", 1, 0, 0);
    chk_period("R9", 14);

    // R2: select write alone changes nothing
    wr_sel(2'b01);
    cyc(50);
    chk(active_src == 0, "R2", "no switch before sleep", int'(active_src), 0);
    chk_period("R2", 14);

    // R3: secondary veto
    sec_en = 0;
    pulse_sleep();
    cyc(100);
    chk(active_src == 0, "R3", "veto keeps primary", int'(active_src), 0);
    chk_flags("R3", 1, 0, 0);

    sec_en = 1;
    pulse_sleep();
    cyc(200);
    chk(active_src == 1, "R5", "secondary committed", int'(active_src), 1);
    chk_flags("R5", 0, 1, 0);
    chk_period("R9", 100);

    // back to internal, slow RC
    wr_sel(2'b10);
    pulse_sleep();
    cyc(250);
    chk(active_src == 2, "R1", "internal committed", int'(active_src), 2);
    chk_flags("R6", 0, 0, 0);
    chk_period("R7", 300);
    mon_en = 0;
    chk(min_phase > 4.9, "R9", "min phase ns during handoffs", int'(min_phase), 5);

    // R8/R7: frequency select, no sleep
    wr_ircf(3'd5);
    cyc(5);
    chk_flags("R6", 0, 0, 1);
    chk_period("R8", 40);
    wr_ircf(3'd7);
    chk_period("R7", 10);
    wr_ircf(3'd1);
    chk_period("R7", 640);
    wr_ircf(3'd6);
    chk_period("R7", 20);
    int_stable = 0;
    cyc(2);
    chk_flags("R6", 0, 0, 0);
    int_stable = 1;

    // R1: 11 also selects internal
    wr_sel(2'b11);
    pulse_sleep();
    cyc(20);
    chk(active_src == 2, "R1", "sel 11 internal", int'(active_src), 2);

    // R1: reset clears select to primary
    rst_ni = 0; cyc(3); rst_ni = 1;
    cyc(100);
    chk(active_src == 2, "R1", "post-reset active_src", int'(active_src), 2);
    chk_period("R1", 300);
    pulse_sleep();
    cyc(5);
    ost_done = 1; cyc(1); ost_done = 0;
    chk(active_src == 0, "R1", "reset select is primary", int'(active_src), 0);
    cyc(200);
    chk_flags("R5", 1, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule